// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the timing ticks for an asynchronous serial port. The bus clock passes through two divider stages. A 9-bit accumulator forwards a fraction FDV/512 of the input cycles. A down-counter then divides the forwarded cycles by (reload + 1) and emits the 16x oversample tick. A divide-by-16 on those ticks yields the bit-rate tick. The resulting bit rate is (FDV/512) × fclk / (16 × (reload + 1)). With these two stages, a bus clock that is not a convenient multiple of the wanted rate can still land close to a standard baud rate.

Software sets the block up through a small write port with three word addresses:

- A control word at address 0 holds the run enable and the fractional-stage enable.
- A fraction word at address 1 holds FDV.
- A reload word at address 2 holds the reload value.

The reload value can only be changed while the generator is stopped. Stopping the generator returns every counter to its start state, so each restart begins from a known phase.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the control word, FDV and reload value are all zero, and neither `os_tick` nor `bit_tick` is asserted.
- R2: While the run bit (bit 15 of the control word, address 0) is 0, no tick of either kind is produced, whatever the other settings are.
- R3: With the run bit set and the fractional enable (bit 9 of the control word) clear, every clock is forwarded. `os_tick` is then a one-cycle pulse every reload+1 clocks. The first pulse falls in the cycle that is `reload` clocks after the cycle in which the run bit is captured. This holds whatever FDV holds.
- R4: With both the run bit and the fractional enable set, and FDV nonzero, the first n cycles after start contain floor(n·FDV/512) forwarded cycles. The number of `os_tick` pulses in that window is floor(floor(n·FDV/512)/(reload+1)).
- R5: With the fractional enable set and FDV equal to 0, every clock is forwarded. The timing is then identical to R3.
- R6: FDV is written at address 1 from bits 8:0 of the write data; higher bits are dropped. Writing 0x200 therefore stores FDV = 0.
- R7: `bit_tick` is a one-cycle pulse that coincides with every 16th `os_tick` after start. It is never asserted without `os_tick`.
- R8: A write to the reload word (address 2) while the run bit is 1 is ignored, and the tick period is unchanged.
- R9: A write to the reload word while the run bit is 0 is stored, and it sets the period at the next start.
- R10: Clearing the run bit resets the accumulator, the reload counter and the divide-by-16 counter. After a restart, the first `os_tick` and the first `bit_tick` arrive with the same timing as after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word select: 0 control, 1 fraction, 2 reload |
| wr_data | input | 16 | Write data |
| os_tick | output | 1 | 16x oversample tick, one cycle wide |
| bit_tick | output | 1 | Bit-rate tick, one cycle wide |

## Verification
Both ticks are combinational functions of registered state. Their timing therefore counts from the edge that captures the control write that sets the run bit; that edge's following cycle is cycle 0.

- The first `os_tick` is due in the first cycle whose forwarded-cycle count, counted inclusively, reaches reload+1.
- The first `bit_tick` is due when that count reaches 16·(reload+1).
- A stop takes effect in the cycle right after its write edge.

The bench drives writes on falling edges. It samples the outputs on every falling edge from cycle 0 onwards and records the index of the first tick and the tick totals over a fixed window. These are compared with values computed from the rate formulas. Windows used for counting periods are whole multiples of the period, so the count does not depend on phase.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int FRAC_W      = 9,
  parameter int RELOAD_W    = 13,
  parameter int OS_RATIO    = 16,
  parameter int DATA_W      = 16,
  parameter int RUN_BIT     = 15,
  parameter int FRAC_EN_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              os_tick,
  output logic              bit_tick
);

  localparam int              DIV_W    = $clog2(OS_RATIO);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(OS_RATIO - 1);
  localparam logic [1:0]       A_CTRL   = 2'd0;
  localparam logic [1:0]       A_FRAC   = 2'd1;
  localparam logic [1:0]       A_RELOAD = 2'd2;

  logic                run, frac_en;
  logic [FRAC_W-1:0]   fdv, acc;
  logic [RELOAD_W-1:0] reload_q, cnt;
  logic [DIV_W-1:0]    div;
  logic [FRAC_W:0]     step, sum;
  logic                frac_pulse;
  logic                unused_wr;

  assign unused_wr  = ^wr_data;

  // FDV of zero counts as a full 512/512 step: every cycle carries.
  assign step       = (fdv == '0) ? {1'b1, {FRAC_W{1'b0}}} : {1'b0, fdv};
  assign sum        = {1'b0, acc} + step;
  assign frac_pulse = frac_en ? sum[FRAC_W] : 1'b1;
  assign os_tick    = run && frac_pulse && (cnt == '0);
  assign bit_tick   = os_tick && (div == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      frac_en  <= 1'b0;
      fdv      <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run     <= wr_data[RUN_BIT];
          frac_en <= wr_data[FRAC_EN_BIT];
        end
        A_FRAC:   fdv <= wr_data[FRAC_W-1:0];
        A_RELOAD: if (!run) reload_q <= wr_data[RELOAD_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
      div <= '0;
    end else if (!run) begin
      acc <= '0;
      cnt <= reload_q;
      div <= '0;
    end else begin
      if (frac_en)    acc <= sum[FRAC_W-1:0];
      if (frac_pulse) cnt <= (cnt == '0) ? reload_q : cnt - RELOAD_W'(1);
      if (os_tick)    div <= (div == DIV_LAST) ? '0 : div + DIV_W'(1);
    end
  end

  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && wr_addr == A_RELOAD) |=> $stable(reload_q)); // R8

  AST_RELOAD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_en && wr_addr == A_RELOAD) |=> reload_q == $past(wr_data[RELOAD_W-1:0])); // R9

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |=> (acc == '0 && div == '0)); // R10

  AST_FULL_RATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (!frac_en || fdv == '0) && cnt != '0) |=> cnt == $past(cnt) - RELOAD_W'(1)); // R5

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= reload_q); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) && !run |-> !os_tick && !bit_tick); // R2

endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        os_tick, bit_tick;

  int checks = 0;
  int fails  = 0;
  int os_n, bit_n, first_os, first_bit, stray;

  frac_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic observe(input int n);
    os_n = 0; bit_n = 0; first_os = -1; first_bit = -1; stray = 0;
    for (int i = 0; i < n; i++) begin
      if (os_tick) begin
        os_n++;
        if (first_os < 0) first_os = i;
      end
      if (bit_tick) begin
        bit_n++;
        if (first_bit < 0) first_bit = i;
        if (!os_tick) stray++;
      end
      @(negedge clk);
    end
  endtask

  // Smallest cycle index whose inclusive forwarded count reaches target.
  function automatic int first_cycle(input int f, input int target);
    for (int k = 0; k < 100000; k++)
      if (((k + 1) * f) / 512 >= target) return k;
    return -1;
  endfunction

  task automatic expect_run(input string tag, input int f, input int r, input int n);
    int fwd;
    fwd = (n * f) / 512;
    observe(n);
    check({tag, " first os_tick"}, first_os, first_cycle(f, r + 1));
    check({tag, " os_tick count"}, os_n, fwd / (r + 1));
    check({tag, " first bit_tick"}, first_bit, first_cycle(f, 16 * (r + 1)));
    check({tag, " bit_tick count"}, bit_n, fwd / (16 * (r + 1)));
    check("R7 bit_tick without os_tick", stray, 0);
  endtask

  task automatic t_reset;
    observe(40);
    check("R1 os_tick after reset", os_n, 0);
    check("R1 bit_tick after reset", bit_n, 0);
  endtask

  task automatic t_stopped;
    wr(2'd2, 16'd4);
    wr(2'd1, 16'd100);
    wr(2'd0, 16'h0200);
    observe(60);
    check("R2 os_tick while stopped", os_n, 0);
    check("R2 bit_tick while stopped", bit_n, 0);
  endtask

  task automatic t_integer;
    // FDV=100 is held but the fractional enable is off
    wr(2'd0, 16'h8000);
    expect_run("R3", 512, 4, 200);
  endtask

  task automatic t_reload_locked;
    wr(2'd2, 16'd9);
    observe(100);
    check("R8 period after write while running", os_n, 20);
    wr(2'd0, 16'h0000);
    observe(30);
    check("R2 os_tick after stop", os_n, 0);
  endtask

  task automatic t_reload_stored;
    wr(2'd2, 16'd9);
    wr(2'd0, 16'h8000);
    observe(400);
    check("R9 os_tick count with new reload", os_n, 40);
    check("R10 first os_tick after restart", first_os, 9);
    check("R10 first bit_tick after restart", first_bit, 159);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_fraction;
    wr(2'd2, 16'd2);
    wr(2'd1, 16'd100);
    wr(2'd0, 16'h8200);
    expect_run("R4 fdv100", 100, 2, 2000);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'd0);
    wr(2'd1, 16'd511);
    wr(2'd0, 16'h8200);
    expect_run("R4 fdv511", 511, 0, 1000);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_fdv_zero;
    wr(2'd2, 16'd3);
    wr(2'd1, 16'h0200);
    wr(2'd0, 16'h8200);
    expect_run("R5 R6 fdv written as 0x200", 512, 3, 640);
    wr(2'd0, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_integer();
    t_reload_locked();
    t_reload_stored();
    t_fraction();
    t_fdv_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule